// File: doc/BRIEF.md
# Wide Instruction Bundle Dispatcher

This block takes one 192-bit instruction word per accepted handshake and splits it into per-unit slots for a parallel cryptographic datapath. The top twelve bits identify the bundle form. A word can carry four 37-bit short operations and one 32-bit control operation. It can carry one 148-bit long operation (a 128-bit permutation or wide shift) and one control operation. It can also be a standalone static-configuration word or a standalone super-long word (immediates, multi-way branch), and neither of those may share the word with anything else.

The outputs are registered and appear one cycle after the word is accepted. Each slot has a valid flag, and an identifier outside the four legal codes raises an illegal flag with no slot valid. The downstream stall input freezes all outputs and drops the input-ready signal. Fetch and the execution units lie outside this block.

Top module: `bundle_dispatch`

## Requirements
- R1: While reset is low and on the first cycle after it, every valid flag and `illegal` are low.
- R2: An accepted word with identifier bits [191:180] = 0x001 gives, on the next cycle, `short_valid` = 4'b1111 and `ctrl_valid` = 1 with all other flags low. Short slot k on `short_slot[37k +: 37]` equals word bits [32+37k +: 37], and `ctrl_slot` equals word bits [31:0].
- R3: Identifier 0x002 gives, on the next cycle, `long_valid` = 1 and `ctrl_valid` = 1 with `short_valid` = 0. `long_slot` equals word bits [179:32].
- R4: Identifier 0x004 gives, on the next cycle, only `cfg_valid` = 1 (`ctrl_valid` is low), and `solo_word` equals word bits [179:0].
- R5: Identifier 0x008 gives, on the next cycle, only `xlong_valid` = 1, with `solo_word` equal to word bits [179:0].
- R6: Any other identifier gives, on the next cycle, `illegal` = 1 with every valid flag low.
- R7: `in_ready` is the inverse of `stall` in the same cycle.
- R8: While `stall` is high, no word is accepted and every output keeps its value from the previous cycle.
- R9: A cycle with `stall` low and `in_valid` low leaves every valid flag and `illegal` low on the next cycle.
- R10: At most one form is flagged at a time (any short, long, config, super-long, illegal), and at most five slot valids are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_word | input | 192 | Instruction word, identifier in [191:180] |
| stall | input | 1 | Downstream stall; freezes outputs |
| short_valid | output | 4 | Per-slot valid for the scalar units |
| short_slot | output | 148 | Four 37-bit short slots, slot k at [37k +: 37] |
| long_valid | output | 1 | Long slot valid |
| long_slot | output | 148 | Long operation for the wide units |
| ctrl_valid | output | 1 | Control slot valid |
| ctrl_slot | output | 32 | Control operation for the sequencer |
| cfg_valid | output | 1 | Standalone configuration word valid |
| xlong_valid | output | 1 | Standalone super-long word valid |
| solo_word | output | 180 | Payload of a standalone word |
| illegal | output | 1 | Unknown identifier seen |

## Verification
On every cycle the assertions check that the forms exclude each other and that the short valids are all set or all clear. They also check that the control valid appears exactly with the short or long form, that a stall freezes the flags, that an idle cycle clears them, and that unknown or long identifiers decode correctly one cycle later. The slot contents show which payload bits reach which unit, and only the bench's scenarios with known payload patterns can show that. The same holds for the interplay of a stall held over several cycles with an offered word that must not be taken.

// File: rtl/disp_pkg.sv
// Shared types and identifier codes for the bundle dispatcher.
// Assumes a 12-bit identifier field at the top of the word.
package disp_pkg;
    typedef enum logic [2:0] {
        FORM_NONE   = 3'd0,
        FORM_SHORT4 = 3'd1,
        FORM_LONG   = 3'd2,
        FORM_CFG    = 3'd3,
        FORM_XLONG  = 3'd4
    } form_e;

    localparam logic [11:0] ID_SHORT4 = 12'h001;
    localparam logic [11:0] ID_LONG   = 12'h002;
    localparam logic [11:0] ID_CFG    = 12'h004;
    localparam logic [11:0] ID_XLONG  = 12'h008;
endpackage

// File: rtl/disp_form_decode.sv
// Maps the identifier field to a bundle form; flags codes that are not legal.
// Assumes ID_W >= 4 so that every code fits.
module disp_form_decode
    import disp_pkg::*;
#(
    parameter int ID_W = 12
) (
    input  logic [ID_W-1:0] id,
    output form_e           form,
    output logic            bad
);
    // Purpose: one-hot code lookup, default is the illegal case.
    always_comb begin
        form = FORM_NONE;
        bad  = 1'b0;
        if (id == ID_W'(ID_SHORT4))      form = FORM_SHORT4;
        else if (id == ID_W'(ID_LONG))   form = FORM_LONG;
        else if (id == ID_W'(ID_CFG))    form = FORM_CFG;
        else if (id == ID_W'(ID_XLONG))  form = FORM_XLONG;
        else                             bad  = 1'b1;
    end
endmodule

// File: rtl/disp_slot_split.sv
// Cuts a stored payload into short, long and control slots.
// Assumes the long slot spans exactly the short slots' bits.
module disp_slot_split #(
    parameter int SHORT_W   = 37,
    parameter int NUM_SHORT = 4,
    parameter int CTRL_W    = 32,
    localparam int LONG_W   = SHORT_W * NUM_SHORT,
    localparam int PAY_W    = LONG_W + CTRL_W
) (
    input  logic [PAY_W-1:0]  payload,
    output logic [LONG_W-1:0] short_flat,
    output logic [LONG_W-1:0] long_slot,
    output logic [CTRL_W-1:0] ctrl_slot
);
    // Purpose: one slice per scalar slot, slot k above the control field.
    for (genvar k = 0; k < NUM_SHORT; k++) begin : g_short
        assign short_flat[k*SHORT_W +: SHORT_W] = payload[CTRL_W + k*SHORT_W +: SHORT_W];
    end

    assign long_slot = payload[PAY_W-1:CTRL_W];
    assign ctrl_slot = payload[CTRL_W-1:0];
endmodule

// File: rtl/disp_out_stage.sv
// Registers the payload once plus per-form valid flags; holds all while stalled.
// Assumes load is only high when hold is low.
module disp_out_stage
    import disp_pkg::*;
#(
    parameter int PAY_W     = 180,
    parameter int NUM_SHORT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 hold,
    input  form_e                form,
    input  logic                 bad,
    input  logic [PAY_W-1:0]     payload_in,
    output logic [PAY_W-1:0]     payload_q,
    output logic [NUM_SHORT-1:0] short_v,
    output logic                 long_v,
    output logic                 ctrl_v,
    output logic                 cfg_v,
    output logic                 xlong_v,
    output logic                 bad_q
);
    // Purpose: capture one accepted word, clear flags when idle, freeze on hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            payload_q <= '0;
            short_v   <= '0;
            long_v    <= 1'b0;
            ctrl_v    <= 1'b0;
            cfg_v     <= 1'b0;
            xlong_v   <= 1'b0;
            bad_q     <= 1'b0;
        end else if (!hold) begin
            if (load) begin
                payload_q <= payload_in;
                short_v   <= {NUM_SHORT{form == FORM_SHORT4}};
                long_v    <= (form == FORM_LONG);
                ctrl_v    <= (form == FORM_SHORT4) || (form == FORM_LONG);
                cfg_v     <= (form == FORM_CFG);
                xlong_v   <= (form == FORM_XLONG);
                bad_q     <= bad;
            end else begin
                short_v   <= '0;
                long_v    <= 1'b0;
                ctrl_v    <= 1'b0;
                cfg_v     <= 1'b0;
                xlong_v   <= 1'b0;
                bad_q     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bundle_dispatch.sv
// Top: accepts a wide instruction word and issues its slots one cycle later.
// Assumes the identifier sits in the top ID_W bits, the control slot in the bottom.
module bundle_dispatch
    import disp_pkg::*;
#(
    parameter int ID_W      = 12,
    parameter int SHORT_W   = 37,
    parameter int NUM_SHORT = 4,
    parameter int CTRL_W    = 32,
    localparam int LONG_W   = SHORT_W * NUM_SHORT,
    localparam int PAY_W    = LONG_W + CTRL_W,
    localparam int WORD_W   = PAY_W + ID_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_word,
    input  logic                 stall,
    output logic [NUM_SHORT-1:0] short_valid,
    output logic [LONG_W-1:0]    short_slot,
    output logic                 long_valid,
    output logic [LONG_W-1:0]    long_slot,
    output logic                 ctrl_valid,
    output logic [CTRL_W-1:0]    ctrl_slot,
    output logic                 cfg_valid,
    output logic                 xlong_valid,
    output logic [PAY_W-1:0]     solo_word,
    output logic                 illegal
);
    form_e            form;
    logic             bad;
    logic             accept;
    logic [PAY_W-1:0] payload_q;

    // Purpose: handshake, ready only when downstream is free.
    assign in_ready = ~stall;
    assign accept   = in_valid & ~stall;

    disp_form_decode #(.ID_W(ID_W)) u_decode (
        .id   (in_word[WORD_W-1 -: ID_W]),
        .form (form),
        .bad  (bad)
    );

    disp_out_stage #(.PAY_W(PAY_W), .NUM_SHORT(NUM_SHORT)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .hold       (stall),
        .form       (form),
        .bad        (bad),
        .payload_in (in_word[PAY_W-1:0]),
        .payload_q  (payload_q),
        .short_v    (short_valid),
        .long_v     (long_valid),
        .ctrl_v     (ctrl_valid),
        .cfg_v      (cfg_valid),
        .xlong_v    (xlong_valid),
        .bad_q      (illegal)
    );

    disp_slot_split #(.SHORT_W(SHORT_W), .NUM_SHORT(NUM_SHORT), .CTRL_W(CTRL_W)) u_split (
        .payload    (payload_q),
        .short_flat (short_slot),
        .long_slot  (long_slot),
        .ctrl_slot  (ctrl_slot)
    );

    assign solo_word = payload_q;
endmodule

// File: rtl/disp_checker.sv
// Property checker for bundle_dispatch, attached by bind below.
// Assumes the default 12-bit identifier codes.
module disp_checker #(
    parameter int ID_W      = 12,
    parameter int NUM_SHORT = 4,
    parameter int WORD_W    = 192
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 stall,
    input logic [WORD_W-1:0]    in_word,
    input logic [NUM_SHORT-1:0] short_valid,
    input logic                 long_valid,
    input logic                 ctrl_valid,
    input logic                 cfg_valid,
    input logic                 xlong_valid,
    input logic                 illegal
);
    logic [ID_W-1:0] id;
    logic            id_known;
    assign id       = in_word[WORD_W-1 -: ID_W];
    assign id_known = (id == ID_W'(12'h001)) || (id == ID_W'(12'h002)) ||
                      (id == ID_W'(12'h004)) || (id == ID_W'(12'h008));

    AST_FORM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|short_valid, long_valid, cfg_valid, xlong_valid, illegal})); // R10

    AST_ISSUE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(short_valid) + 32'(long_valid) + 32'(ctrl_valid)) <= 5); // R10

    AST_SHORT_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (short_valid == '0) || (short_valid == '1)); // R2

    AST_CTRL_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid == ((short_valid == '1) || long_valid)); // R4

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable({short_valid, long_valid, ctrl_valid, cfg_valid, xlong_valid, illegal})); // R8

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !stall) |=> !(|{short_valid, long_valid, ctrl_valid, cfg_valid, xlong_valid, illegal})); // R9

    AST_UNKNOWN_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall && !id_known) |=> (illegal && !ctrl_valid && short_valid == '0)); // R6

    AST_LONG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall && id == ID_W'(12'h002)) |=> (long_valid && ctrl_valid && short_valid == '0)); // R3
endmodule

bind bundle_dispatch disp_checker #(.ID_W(ID_W), .NUM_SHORT(NUM_SHORT), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .stall       (stall),
    .in_word     (in_word),
    .short_valid (short_valid),
    .long_valid  (long_valid),
    .ctrl_valid  (ctrl_valid),
    .cfg_valid   (cfg_valid),
    .xlong_valid (xlong_valid),
    .illegal     (illegal)
);

// File: tb/tb_bundle_dispatch.sv
// Bench: behavioural per-cycle model, compared on every falling edge.
module tb_bundle_dispatch;
    localparam int WW = 192;
    localparam int PW = 180;
    localparam int SW = 37;
    localparam int NS = 4;
    localparam int LW = 148;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          stall = 1'b0;
    logic [WW-1:0] in_word = '0;
    logic          in_ready;
    logic [NS-1:0] short_valid;
    logic [LW-1:0] short_slot;
    logic          long_valid;
    logic [LW-1:0] long_slot;
    logic          ctrl_valid;
    logic [31:0]   ctrl_slot;
    logic          cfg_valid;
    logic          xlong_valid;
    logic [PW-1:0] solo_word;
    logic          illegal;

    bundle_dispatch dut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_tag = "R1";
    string tag_q   = "R1";

    // Model state.
    int            m_flags[6];       // short-all, long, ctrl, cfg, xlong, illegal
    logic [PW-1:0] m_pay;

    task automatic chk(input string tag, input string what, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Model update at each rising edge from the inputs driven after the previous one.
    always @(posedge clk) begin
        tag_q = cur_tag;
        if (!rst_n) begin
            foreach (m_flags[i]) m_flags[i] = 0;
            m_pay = '0;
        end else if (!stall) begin
            foreach (m_flags[i]) m_flags[i] = 0;
            if (in_valid) begin
                m_pay = in_word[PW-1:0];
                case (in_word[WW-1:PW])
                    12'h001: begin m_flags[0] = 1; m_flags[2] = 1; end
                    12'h002: begin m_flags[1] = 1; m_flags[2] = 1; end
                    12'h004: m_flags[3] = 1;
                    12'h008: m_flags[4] = 1;
                    default: m_flags[5] = 1;
                endcase
            end
        end
    end

    // Comparison away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            logic [LW-1:0] exp_short;
            for (int k = 0; k < NS; k++) exp_short[k*SW +: SW] = m_pay[32 + k*SW +: SW];
            chk("R7", "in_ready", PW'(in_ready), PW'(!stall));
            chk(tag_q, "short_valid", PW'(short_valid), PW'(m_flags[0] != 0 ? 4'hF : 4'h0));
            chk(tag_q, "long_valid",  PW'(long_valid),  PW'(m_flags[1]));
            chk(tag_q, "ctrl_valid",  PW'(ctrl_valid),  PW'(m_flags[2]));
            chk(tag_q, "cfg_valid",   PW'(cfg_valid),   PW'(m_flags[3]));
            chk(tag_q, "xlong_valid", PW'(xlong_valid), PW'(m_flags[4]));
            chk(tag_q, "illegal",     PW'(illegal),     PW'(m_flags[5]));
            chk(tag_q, "short_slot",  PW'(short_slot),  PW'(exp_short));
            chk(tag_q, "long_slot",   PW'(long_slot),   PW'(m_pay[PW-1:32]));
            chk(tag_q, "ctrl_slot",   PW'(ctrl_slot),   PW'(m_pay[31:0]));
            chk(tag_q, "solo_word",   solo_word,        m_pay);
            chk("R10", "form_count",
                PW'((|short_valid) + long_valid + cfg_valid + xlong_valid + illegal <= 1), PW'(1));
        end
    end

    function automatic logic [WW-1:0] mk(input logic [11:0] id, input int seed);
        logic [PW-1:0] p;
        for (int i = 0; i < 6; i++) p[i*30 +: 30] = 30'(32'h2F1B_9C37 * (seed + i + 1) ^ (i * 32'h0555_1234));
        return {id, p};
    endfunction

    task automatic drive(input logic v, input logic s, input logic [WW-1:0] w, input string tag);
        @(posedge clk);
        #1;
        in_valid = v;
        stall    = s;
        in_word  = w;
        cur_tag  = tag;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(0, 0, '0, "R1");
        drive(1, 0, mk(12'h001, 1), "R2");
        drive(1, 0, mk(12'h001, 2), "R2");
        drive(1, 0, mk(12'h002, 3), "R3");
        drive(1, 0, mk(12'h004, 4), "R4");
        drive(1, 0, mk(12'h008, 5), "R5");
        drive(1, 0, mk(12'h003, 6), "R6");
        drive(1, 0, mk(12'h000, 7), "R6");
        drive(1, 0, mk(12'h801, 8), "R6");
        drive(0, 0, mk(12'h001, 9), "R9");
        drive(1, 0, mk(12'h002, 10), "R3");
        drive(1, 1, mk(12'hFFF, 11), "R8");
        drive(1, 1, mk(12'h004, 12), "R8");
        drive(0, 1, '0, "R8");
        drive(0, 0, '0, "R9");
        drive(1, 0, mk(12'h008, 13), "R5");
        drive(1, 1, mk(12'h001, 14), "R8");
        drive(1, 0, mk(12'h001, 15), "R2");
        for (int i = 0; i < 40; i++) begin
            logic [11:0] ids[5] = '{12'h001, 12'h002, 12'h004, 12'h008, 12'h010};
            string tags[5] = '{"R2", "R3", "R4", "R5", "R6"};
            int sel = int'($urandom_range(0, 4));
            if (i % 7 == 3) drive(1, 1, mk(ids[sel], 100 + i), "R8");
            else            drive(1, 0, mk(ids[sel], 100 + i), tags[sel]);
        end
        drive(0, 0, '0, "R9");
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1 done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule